// File: doc/BRIEF.md
# Input Frequency Band Classifier

This block chooses which of six input-frequency bands a clock multiplier is being fed and reports the feedback divide ratio that lifts that band to the loop's fixed internal frequency. The six bands are spaced by factors of two, from about 19.4–20.9 MHz at the bottom to 622–667 MHz at the top. The ratio is 32 for the lowest band and halves for each band above it, down to 1 for the highest.

The choice comes from two configuration pins, each already resolved to low, mid or high. Together they give nine codes. Six of them name a band directly. Two are reserved and never yield a band. The code with both pins at mid starts automatic detection.

In automatic detection the block counts edges of the input clock over a fixed window of reference cycles. The input clock is presented as a one-cycle strobe per edge, already in the reference domain after any prescaling. The count is compared with the count limits of each band. A band is accepted only when two back-to-back windows agree on it. A window that fits no band raises a band-not-found flag. Any change on the configuration pins restarts classification.

Top module: `freq_band_classifier`

## Requirements
- R1: Pin levels are encoded low=2'b00, mid=2'b01, high=2'b10, and codes are written as (sel_a_i, sel_b_i). The direct codes map to band index as follows: high-high gives 0, high-low gives 1, mid-high gives 2, mid-low gives 3, low-high gives 4 and low-low gives 5. When a direct code is held, valid_o rises one cycle after the cycle in which the restart occurred.
- R2: While valid_o is high, fb_div_o equals 2^(5-band_o), so band 0 gives 32 and band 5 gives 1. While valid_o is low, both fb_div_o and band_o are 0.
- R3: The codes high-mid and low-mid, and any code with a pin at 2'b11, are reserved. While one of them is held, valid_o is low and band_miss_o is low.
- R4: A clock edge at which the pin code differs from the code seen at the previous edge clears valid_o and band_miss_o and restarts measurement.
- R5: Code mid-mid selects automatic mode. Strobes on edge_tick_i are counted over windows of WIN_CYC reference cycles, and the first window starts at the restart edge. Band k matches a count C when LO_CNT0·2^k ≤ C ≤ HI_CNT0·2^k. With the defaults (128, 2, 3), band k matches counts from 2·2^k to 3·2^k.
- R6: In automatic mode valid_o rises only after two consecutive windows match the same band. From a restart edge e0 this happens at edge e0+2·WIN_CYC+1 at the earliest. A window whose band differs from the one before it leaves valid_o low.
- R7: An automatic window whose count fits no band sets band_miss_o and clears valid_o. A later window that matches a band clears band_miss_o.
- R8: During reset valid_o, band_miss_o, band_o and fb_div_o are all 0.
- R9: valid_o and band_miss_o are never high together, and band_o does not change while valid_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also times the measurement window |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_i | input | 2 | First configuration pin level (low/mid/high) |
| sel_b_i | input | 2 | Second configuration pin level (low/mid/high) |
| edge_tick_i | input | 1 | One-cycle strobe per input-clock edge |
| band_o | output | 3 | Selected band index, 0 = lowest |
| fb_div_o | output | 6 | Feedback divide ratio, one-hot power of two |
| valid_o | output | 1 | Band and ratio are valid |
| band_miss_o | output | 1 | Last automatic window matched no band |

## Verification
The hardest case to reach from the ports is an automatic window that matches a band different from the window before it, because that needs the input rate to change close to a window boundary. The stimulus starts automatic mode with the strobe silent, so the first window misses. It then switches the strobe to one every three cycles just after that window closes. The second window therefore lands in band 4 with no earlier agreement, and valid_o must stay low until the third window confirms the band. Exact-count boundaries are reached with strobe periods that divide the window, so each window gets a known count, including the lowest legal count of band 0, an empty window and a completely full window.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int NBAND = 6;
  localparam int BW    = 3;

  localparam logic [1:0] LVL_LO  = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;
  localparam logic [1:0] LVL_HI  = 2'b10;

  // ratio relative to the top band: band 0 -> 2^(NBAND-1)
  function automatic logic [NBAND-1:0] div_of(input logic [BW-1:0] b);
    logic [NBAND-1:0] one;
    one = {{(NBAND-1){1'b0}}, 1'b1};
    return one << (NBAND - 1 - int'(b));
  endfunction
endpackage

// File: rtl/fbc_code_decode.sv
module fbc_code_decode
  import fbc_pkg::*;
(
  input  logic [1:0]    sel_a,
  input  logic [1:0]    sel_b,
  output logic          man_ok,
  output logic          auto_sel,
  output logic [BW-1:0] man_band
);
  always_comb begin
    man_ok   = 1'b1;
    auto_sel = 1'b0;
    man_band = '0;
    case ({sel_a, sel_b})
      {LVL_HI,  LVL_HI }: man_band = BW'(0);
      {LVL_HI,  LVL_LO }: man_band = BW'(1);
      {LVL_MID, LVL_HI }: man_band = BW'(2);
      {LVL_MID, LVL_LO }: man_band = BW'(3);
      {LVL_LO,  LVL_HI }: man_band = BW'(4);
      {LVL_LO,  LVL_LO }: man_band = BW'(5);
      {LVL_MID, LVL_MID}: begin
        man_ok   = 1'b0;
        auto_sel = 1'b1;
      end
      default: man_ok = 1'b0;  // reserved or illegal level
    endcase
  end
endmodule

// File: rtl/fbc_edge_meter.sv
module fbc_edge_meter #(
  parameter int WIN = 128,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic          done,
  output logic [CW-1:0] count
);
  localparam int WW = $clog2(WIN);

  logic [WW-1:0] wcnt_q, wcnt_n;
  logic [CW-1:0] ecnt_q, ecnt_n, ecnt_inc;
  logic          win_end, load_en;

  always_comb begin
    ecnt_inc = ecnt_q + {{(CW-1){1'b0}}, tick};
    win_end  = (wcnt_q == WW'(WIN - 1));
    load_en  = win_end & ~restart;
    wcnt_n   = win_end ? '0 : wcnt_q + 1'b1;
    ecnt_n   = win_end ? '0 : ecnt_inc;
    if (restart) begin
      wcnt_n = '0;
      ecnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
      done   <= 1'b0;
      count  <= '0;
    end else begin
      wcnt_q <= wcnt_n;
      ecnt_q <= ecnt_n;
      done   <= load_en;
      if (load_en) count <= ecnt_inc;
    end
  end
endmodule

// File: rtl/fbc_band_match.sv
module fbc_band_match
  import fbc_pkg::*;
#(
  parameter int CW  = 8,
  parameter int LO0 = 2,
  parameter int HI0 = 3
) (
  input  logic [CW-1:0] count,
  output logic          found,
  output logic [BW-1:0] band
);
  logic [NBAND-1:0] hit;

  for (genvar k = 0; k < NBAND; k++) begin : g_band
    localparam int LO_K = LO0 << k;
    localparam int HI_K = HI0 << k;
    assign hit[k] = (int'(count) >= LO_K) && (int'(count) <= HI_K);
  end

  always_comb begin
    found = |hit;
    band  = '0;
    for (int k = NBAND - 1; k >= 0; k--) begin
      if (hit[k]) band = BW'(k);
    end
  end
endmodule

// File: rtl/freq_band_classifier.sv
module freq_band_classifier
  import fbc_pkg::*;
#(
  parameter int WIN_CYC = 128,
  parameter int LO_CNT0 = 2,
  parameter int HI_CNT0 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel_a_i,
  input  logic [1:0]       sel_b_i,
  input  logic             edge_tick_i,
  output logic [BW-1:0]    band_o,
  output logic [NBAND-1:0] fb_div_o,
  output logic             valid_o,
  output logic             band_miss_o
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [3:0]       cfg_w, cfg_q;
  logic             restart, man_ok, auto_sel, meas_done, found;
  logic [BW-1:0]    man_band, mband;
  logic [CW-1:0]    meas_cnt;
  logic             pok_q, pok_n, valid_n, miss_n;
  logic [BW-1:0]    pband_q, pband_n, band_n;
  logic [NBAND-1:0] div_n;

  assign cfg_w   = {sel_a_i, sel_b_i};
  assign restart = (cfg_w != cfg_q);

  fbc_code_decode u_dec (
    .sel_a(sel_a_i), .sel_b(sel_b_i),
    .man_ok(man_ok), .auto_sel(auto_sel), .man_band(man_band)
  );

  fbc_edge_meter #(.WIN(WIN_CYC), .CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(edge_tick_i),
    .done(meas_done), .count(meas_cnt)
  );

  fbc_band_match #(.CW(CW), .LO0(LO_CNT0), .HI0(HI_CNT0)) u_match (
    .count(meas_cnt), .found(found), .band(mband)
  );

  always_comb begin
    valid_n = valid_o;
    miss_n  = band_miss_o;
    band_n  = band_o;
    pok_n   = pok_q;
    pband_n = pband_q;
    if (restart) begin
      valid_n = 1'b0;
      miss_n  = 1'b0;
      band_n  = '0;
      pok_n   = 1'b0;
      pband_n = '0;
    end else if (man_ok) begin
      valid_n = 1'b1;
      miss_n  = 1'b0;
      band_n  = man_band;
    end else if (auto_sel) begin
      if (meas_done) begin
        if (found) begin
          pok_n   = 1'b1;
          pband_n = mband;
          miss_n  = 1'b0;
          if (pok_q && (pband_q == mband)) begin
            valid_n = 1'b1;
            band_n  = mband;
          end else begin
            valid_n = 1'b0;
            band_n  = '0;
          end
        end else begin
          pok_n   = 1'b0;
          valid_n = 1'b0;
          miss_n  = 1'b1;
          band_n  = '0;
        end
      end
    end else begin
      valid_n = 1'b0;
      miss_n  = 1'b0;
      band_n  = '0;
    end
    div_n = valid_n ? div_of(band_n) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      valid_o     <= 1'b0;
      band_miss_o <= 1'b0;
      band_o      <= '0;
      fb_div_o    <= '0;
      pok_q       <= 1'b0;
      pband_q     <= '0;
    end else begin
      cfg_q       <= cfg_w;
      valid_o     <= valid_n;
      band_miss_o <= miss_n;
      band_o      <= band_n;
      fb_div_o    <= div_n;
      pok_q       <= pok_n;
      pband_q     <= pband_n;
    end
  end
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker
  import fbc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel_a_i,
  input logic [1:0]       sel_b_i,
  input logic             edge_tick_i,
  input logic [BW-1:0]    band_o,
  input logic [NBAND-1:0] fb_div_o,
  input logic             valid_o,
  input logic             band_miss_o
);
  logic [3:0] cfg;
  logic       direct, reserved;
  assign cfg      = {sel_a_i, sel_b_i};
  assign direct   = (cfg == {LVL_HI, LVL_HI}) || (cfg == {LVL_HI, LVL_LO}) ||
                    (cfg == {LVL_MID, LVL_HI}) || (cfg == {LVL_MID, LVL_LO}) ||
                    (cfg == {LVL_LO, LVL_HI}) || (cfg == {LVL_LO, LVL_LO});
  assign reserved = !direct && (cfg != {LVL_MID, LVL_MID});

  AST_DIRECT_HELD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && $past(rst_n) && $past(rst_n, 2) && cfg == $past(cfg) && cfg == $past(cfg, 2))
      |-> valid_o);  // R1
  AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($countones(fb_div_o) == 1));  // R2
  AST_DIV_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (fb_div_o == '0 && band_o == '0));  // R2
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (reserved && $past(rst_n) && cfg == $past(cfg)) |-> (!valid_o && !band_miss_o));  // R3
  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg != $past(cfg)) |=> !valid_o);  // R4
  AST_MISS_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    band_miss_o |-> ($past(cfg) == {LVL_MID, LVL_MID}));  // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && band_miss_o));  // R9
  AST_BAND_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(band_o));  // R9
endmodule

bind freq_band_classifier fbc_checker u_chk (.*);

// File: tb/sim_freq_band_classifier.sv
`timescale 1ns/1ps
module sim_freq_band_classifier;
  localparam int WIN = 128;
  localparam logic [1:0] LO = 2'b00, MD = 2'b01, HI = 2'b10, BAD = 2'b11;

  logic       clk, rst_n, tick;
  logic [1:0] sa, sb;
  logic [2:0] band;
  logic [5:0] div;
  logic       valid, miss;
  int         tests, failed, per, ph;
  bit         done_flag;

  freq_band_classifier #(.WIN_CYC(WIN), .LO_CNT0(2), .HI_CNT0(3)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_a_i(sa), .sel_b_i(sb), .edge_tick_i(tick),
    .band_o(band), .fb_div_o(div), .valid_o(valid), .band_miss_o(miss)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // strobe generator: one tick every per cycles, off when per == 0
  always @(negedge clk) begin
    if (per == 0) begin
      tick <= 1'b0;
      ph   <= 0;
    end else if (ph >= per - 1) begin
      tick <= 1'b1;
      ph   <= 0;
    end else begin
      tick <= 1'b0;
      ph   <= ph + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a new code; returns just after the restart edge, at the negedge
  task automatic set_cfg(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    sa = a;
    sb = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 valid in reset", valid, 0);
    check("R8 miss in reset", miss, 0);
    check("R8 band in reset", band, 0);
    check("R8 div in reset", div, 0);
  endtask

  task automatic t_direct(input logic [1:0] a, input logic [1:0] b, input int exp_band);
    set_cfg(a, b);
    check("R4 valid cleared after code change", valid, 0);
    wait_cyc(1);
    check("R1 valid for direct code", valid, 1);
    check("R1 band for direct code", band, exp_band);
    check("R2 divide ratio", div, 32 >> exp_band);
    check("R9 no miss with direct code", miss, 0);
  endtask

  task automatic t_reserved(input logic [1:0] a, input logic [1:0] b);
    set_cfg(a, b);
    wait_cyc(3);
    check("R3 reserved valid low", valid, 0);
    check("R3 reserved miss low", miss, 0);
    check("R2 ratio zero when invalid", div, 0);
  endtask

  task automatic t_auto(input int period, input int exp_band);
    set_cfg(HI, HI);
    per = period;
    wait_cyc(4);
    set_cfg(MD, MD);                 // restart edge e0 just passed
    wait_cyc(2 * WIN - 4);           // before second window result
    check("R6 not valid after one window", valid, 0);
    wait_cyc(6);
    check("R5 auto valid", valid, 1);
    check("R5 auto band", band, exp_band);
    check("R2 auto ratio", div, 32 >> exp_band);
    check("R9 auto no miss", miss, 0);
  endtask

  task automatic t_miss(input int period);
    set_cfg(HI, HI);
    per = period;
    wait_cyc(4);
    set_cfg(MD, MD);
    wait_cyc(WIN + 4);
    check("R7 miss after empty/full window", miss, 1);
    check("R7 valid low on miss", valid, 0);
  endtask

  task automatic t_two_windows();
    set_cfg(HI, HI);
    per = 0;
    wait_cyc(4);
    set_cfg(MD, MD);
    wait_cyc(WIN + 1);               // first window closes silent
    per = 3;                         // about 42 strobes per window: band 4
    wait_cyc(WIN + 2);
    check("R6 single agreeing window not enough", valid, 0);
    check("R7 miss cleared by matching window", miss, 0);
    wait_cyc(WIN);
    check("R6 valid after second agreeing window", valid, 1);
    check("R6 band after agreement", band, 4);
    set_cfg(LO, LO);
    check("R4 auto result cleared by code change", valid, 0);
    wait_cyc(1);
    check("R1 low-low after auto", band, 5);
  endtask

  initial begin
    tests = 0; failed = 0; per = 0; ph = 0; done_flag = 0;
    tick = 1'b0; sa = LO; sb = LO; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    check("R1 low-low held through reset", band, 5);
    t_direct(HI, HI, 0);
    t_direct(HI, LO, 1);
    t_direct(MD, HI, 2);
    t_direct(MD, LO, 3);
    t_direct(LO, HI, 4);
    t_direct(LO, LO, 5);
    t_reserved(HI, MD);
    t_reserved(LO, MD);
    t_reserved(BAD, HI);
    t_auto(64, 0);
    t_auto(32, 1);
    t_auto(16, 2);
    t_auto(8, 3);
    t_auto(4, 4);
    t_auto(2, 5);
    t_miss(0);
    t_miss(1);
    t_two_windows();
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      tests++;
      failed++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule